// File: doc/BRIEF.md
# Boot Security Lock Controller

This block sits on the address bus of a 16-bit host CPU that uses separate upper and lower byte strobes. It keeps the host from reaching the video display processor until a four-byte security register holds an ASCII signature. While the register holds anything else, every access to the video address pages is refused and raises a sticky lockup flag. The signature is checked again after every write to the register, so software can unlock the video chip and later lock it again.

The block also holds a one-bit bank register that chooses what answers at address zero: the internal 2 KB boot ROM or the cartridge ROM. The register can be read back. The block decodes each bus cycle and produces registered selects for the video chip, the boot ROM and the cartridge. A hard reset clears the security bytes and sets the bank according to two configuration straps. A soft reset leaves both untouched and clears only the lockup flag.

Top module: `boot_lock_ctrl`

## Requirements
- R1: A hard reset (`rst_i`) clears all four security bytes, so the video chip is locked while `lock_en_i` is 1. A soft reset (`soft_rst_i`) leaves the security bytes unchanged.
- R2: `vdp_open_o` is 1 only when the security bytes at offsets 0, 1, 2 and 3 from `SEC_BASE` hold 0x53, 0x45, 0x47 and 0x41 in that order. Any other content, including the same letters in a different order, keeps it at 0.
- R3: In a write to the security register, address bit 1 selects the byte pair. `uds_i` writes the even byte from `wdata_i[15:8]` and `lds_i` writes the odd byte from `wdata_i[7:0]`. With a single strobe, only that one byte changes.
- R4: The signature is checked again after every security write. `vdp_open_o` follows the new content one cycle after the write, so a write that breaks the signature locks the video chip again.
- R5: The video region is every access whose `addr_i[23:16]` is 0xC0, 0xC8, 0xD0 or 0xD8. Other pages, such as 0xC1 or 0xE0, are not part of the video region.
- R6: A video-region access while `vdp_open_o` is 1 pulses `vdp_cs_o` in the next cycle. While `vdp_open_o` is 0, the same access gives no `vdp_cs_o` and sets `lockup_o`, which stays at 1 until a hard or soft reset.
- R7: With `lock_en_i` at 0, `vdp_open_o` is 1 whatever the security bytes hold, and video accesses never set `lockup_o`.
- R8: A write to `BANK_ADDR` with `lds_i` asserted loads `wdata_i[0]` into the bank register (1 selects the cartridge, 0 selects the boot ROM), shown on `bank_cart_o`. A write with only `uds_i` asserted leaves the bank unchanged.
- R9: A read of `BANK_ADDR` returns the bank bit on `rdata_o[0]`, with the upper bits at 0, in the next cycle. Every other read returns 0.
- R10: A hard reset sets the bank to the boot ROM (0) when both `lock_en_i` and `boot_en_i` are 1, and to the cartridge (1) otherwise. A soft reset keeps the bank.
- R11: An access below 0x000800 while the bank is 0 pulses `boot_cs_o`. Any other access below 0x800000 pulses `cart_cs_o`. Both pulse in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous hard reset, active high |
| soft_rst_i | input | 1 | Synchronous soft reset, clears the lockup flag only |
| lock_en_i | input | 1 | Strap: enables the video lock |
| boot_en_i | input | 1 | Strap: map the boot ROM at hard reset |
| acc_i | input | 1 | A bus cycle is presented this clock |
| we_i | input | 1 | 1 = write, 0 = read |
| uds_i | input | 1 | Upper (even) byte strobe |
| lds_i | input | 1 | Lower (odd) byte strobe |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data |
| vdp_open_o | output | 1 | Video chip unlocked |
| vdp_cs_o | output | 1 | Granted video access |
| lockup_o | output | 1 | Sticky: a video access was refused |
| boot_cs_o | output | 1 | Boot ROM select |
| cart_cs_o | output | 1 | Cartridge select |
| bank_cart_o | output | 1 | Bank register: 1 = cartridge at zero |
| rdata_o | output | 16 | Read data for the bank register |

## Verification
Every result shows up on the outputs one clock after the edge that takes in the access. The selects, the read data and the lockup flag come from the current lock and bank state. The lock state and the bank bit themselves take on a write's effect at the same edge, so the first access that sees them is the next one. The bench drives inputs on falling edges and runs its reference model on rising edges. It compares every output on the following falling edge, which is where each of these one-cycle results is due. Directed checks placed right after each bus cycle sample at that same point.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;
  typedef enum logic {
    BANK_BOOT = 1'b0,
    BANK_CART = 1'b1
  } bank_src_e;

  localparam logic [31:0] SIG_UNLOCK = 32'h5345_4741;
endpackage

// File: rtl/bl_decode.sv
module bl_decode #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned SEC_BYTES   = 4,
  parameter logic [ADDR_W-1:0] SEC_BASE  = 24'hA14000,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 24'hA14100,
  parameter int unsigned VDP_PAGE_LO = 8'hC0,
  parameter int unsigned VDP_PAGE_HI = 8'hDF,
  parameter int unsigned VDP_STRIDE  = 8,
  parameter int unsigned BOOT_BYTES  = 2048,
  parameter int unsigned CART_BYTES  = 24'h800000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vdp_hit_o,
  output logic              sec_hit_o,
  output logic              bank_hit_o,
  output logic              boot_rng_o,
  output logic              cart_rng_o
);
  localparam int unsigned SEC_AW = $clog2(SEC_BYTES);
  localparam int unsigned NPG    = (VDP_PAGE_HI - VDP_PAGE_LO) / VDP_STRIDE + 1;
  localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_BYTES);
  localparam logic [ADDR_W-1:0] CART_LIM = ADDR_W'(CART_BYTES);

  logic [7:0]     page;
  logic [NPG-1:0] page_eq;

  assign page = addr_i[ADDR_W-1 -: 8];

  for (genvar g = 0; g < NPG; g++) begin : g_page
    assign page_eq[g] = (page == 8'(VDP_PAGE_LO + g * VDP_STRIDE));
  end

  assign vdp_hit_o  = |page_eq;
  assign sec_hit_o  = (addr_i[ADDR_W-1:SEC_AW] == SEC_BASE[ADDR_W-1:SEC_AW]);
  assign bank_hit_o = (addr_i[ADDR_W-1:1] == BANK_ADDR[ADDR_W-1:1]);
  assign boot_rng_o = (addr_i < BOOT_LIM);
  assign cart_rng_o = (addr_i < CART_LIM);
endmodule

// File: rtl/bl_sec_reg.sv
module bl_sec_reg #(
  parameter int unsigned NB = 4,
  parameter logic [8*NB-1:0] SIG = 32'h5345_4741
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     word_i,
  input  logic                 uds_i,
  input  logic                 lds_i,
  input  logic [15:0]          wdata_i,
  output logic                 match_nxt_o
);
  localparam int unsigned IDX_W = $clog2(NB) - 1;

  logic [8*NB-1:0] sec_q;
  logic [8*NB-1:0] sec_nxt;
  logic [NB-1:0]   byte_eq;
  logic            armed_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic       lane;
    logic [7:0] src;
    assign lane = (b % 2 == 0) ? uds_i : lds_i;
    assign src  = (b % 2 == 0) ? wdata_i[15:8] : wdata_i[7:0];
    assign sec_nxt[(NB-1-b)*8 +: 8] =
      (wr_en_i && lane && (word_i == IDX_W'(b / 2))) ? src : sec_q[(NB-1-b)*8 +: 8];
    assign byte_eq[b] = (sec_nxt[(NB-1-b)*8 +: 8] == SIG[(NB-1-b)*8 +: 8]);
  end

  assign match_nxt_o = &byte_eq;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      sec_q   <= sec_nxt;
      armed_q <= 1'b1;
    end
  end

  // security bytes move only on a register write (R3)
  assert_sec_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    !wr_en_i |=> $stable(sec_q));
endmodule

// File: rtl/bl_bank.sv
module bl_bank
  import boot_lock_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      lock_en_i,
  input  logic      boot_en_i,
  input  logic      wr_en_i,
  input  logic      wbit_i,
  output bank_src_e bank_o
);
  bank_src_e bank_q;
  logic      armed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bank_q  <= (lock_en_i && boot_en_i) ? BANK_BOOT : BANK_CART;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (wr_en_i) bank_q <= wbit_i ? BANK_CART : BANK_BOOT;
    end
  end

  assign bank_o = bank_q;

  // bank changes outside reset only after a bank write (R8)
  assert_bank_src_R8: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    !$stable(bank_q) |-> $past(wr_en_i));
endmodule

// File: rtl/boot_lock_ctrl.sv
module boot_lock_ctrl
  import boot_lock_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SEC_BYTES   = 4,
  parameter logic [8*SEC_BYTES-1:0] SIGNATURE = SIG_UNLOCK,
  parameter logic [ADDR_W-1:0] SEC_BASE  = 24'hA14000,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 24'hA14100,
  parameter int unsigned VDP_PAGE_LO = 8'hC0,
  parameter int unsigned VDP_PAGE_HI = 8'hDF,
  parameter int unsigned VDP_STRIDE  = 8,
  parameter int unsigned BOOT_BYTES  = 2048,
  parameter int unsigned CART_BYTES  = 24'h800000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              soft_rst_i,
  input  logic              lock_en_i,
  input  logic              boot_en_i,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic              uds_i,
  input  logic              lds_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              vdp_open_o,
  output logic              vdp_cs_o,
  output logic              lockup_o,
  output logic              boot_cs_o,
  output logic              cart_cs_o,
  output logic              bank_cart_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned SEC_AW = $clog2(SEC_BYTES);

  logic vdp_hit, sec_hit, bank_hit, boot_rng, cart_rng;
  logic match_nxt;
  bank_src_e bank;
  logic boot_mapped;

  logic open_q, vdp_cs_q, lockup_q, boot_cs_q, cart_cs_q, armed_q;
  logic [DATA_W-1:0] rdata_q;

  bl_decode #(
    .ADDR_W(ADDR_W), .SEC_BYTES(SEC_BYTES), .SEC_BASE(SEC_BASE), .BANK_ADDR(BANK_ADDR),
    .VDP_PAGE_LO(VDP_PAGE_LO), .VDP_PAGE_HI(VDP_PAGE_HI), .VDP_STRIDE(VDP_STRIDE),
    .BOOT_BYTES(BOOT_BYTES), .CART_BYTES(CART_BYTES)
  ) u_dec (
    .addr_i(addr_i), .vdp_hit_o(vdp_hit), .sec_hit_o(sec_hit), .bank_hit_o(bank_hit),
    .boot_rng_o(boot_rng), .cart_rng_o(cart_rng)
  );

  bl_sec_reg #(.NB(SEC_BYTES), .SIG(SIGNATURE)) u_sec (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(acc_i && we_i && sec_hit),
    .word_i(addr_i[SEC_AW-1:1]),
    .uds_i(uds_i), .lds_i(lds_i), .wdata_i(wdata_i[15:0]),
    .match_nxt_o(match_nxt)
  );

  bl_bank u_bank (
    .clk_i(clk_i), .rst_i(rst_i), .lock_en_i(lock_en_i), .boot_en_i(boot_en_i),
    .wr_en_i(acc_i && we_i && bank_hit && lds_i), .wbit_i(wdata_i[0]),
    .bank_o(bank)
  );

  assign boot_mapped = boot_rng && (bank == BANK_BOOT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      open_q    <= ~lock_en_i;
      vdp_cs_q  <= 1'b0;
      lockup_q  <= 1'b0;
      boot_cs_q <= 1'b0;
      cart_cs_q <= 1'b0;
      rdata_q   <= '0;
      armed_q   <= 1'b0;
    end else begin
      armed_q   <= 1'b1;
      open_q    <= ~lock_en_i | match_nxt;
      vdp_cs_q  <= acc_i && vdp_hit && open_q;
      if (soft_rst_i)                      lockup_q <= 1'b0;
      else if (acc_i && vdp_hit && !open_q) lockup_q <= 1'b1;
      boot_cs_q <= acc_i && boot_mapped;
      cart_cs_q <= acc_i && cart_rng && !boot_mapped;
      rdata_q   <= (acc_i && !we_i && bank_hit)
                   ? {{(DATA_W-1){1'b0}}, bank == BANK_CART} : '0;
    end
  end

  assign vdp_open_o  = open_q;
  assign vdp_cs_o    = vdp_cs_q;
  assign lockup_o    = lockup_q;
  assign boot_cs_o   = boot_cs_q;
  assign cart_cs_o   = cart_cs_q;
  assign bank_cart_o = (bank == BANK_CART);
  assign rdata_o     = rdata_q;

  // a granted video access needs the lock open in the cycle before (R6)
  assert_cs_gated_R6: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    vdp_cs_o |-> $past(vdp_open_o));
  // lockup flag holds until a reset (R6)
  assert_lockup_sticky_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    lockup_o && !soft_rst_i |=> lockup_o);
  // lock strap low keeps the video chip open (R7)
  assert_open_strap_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !lock_en_i |=> vdp_open_o);
  // region selects never overlap (R11)
  assert_regions_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({boot_cs_o, cart_cs_o, vdp_cs_o}));
endmodule

// File: tb/boot_lock_ctrl_tb.sv
`timescale 1ns/1ps
module boot_lock_ctrl_tb;
  localparam logic [23:0] SEC  = 24'hA14000;
  localparam logic [23:0] BNK  = 24'hA14100;

  logic clk = 1'b0;
  logic rst, soft_rst, lock_en, boot_en, acc, we, uds, lds;
  logic [23:0] addr;
  logic [15:0] wdata;
  logic vdp_open, vdp_cs, lockup, boot_cs, cart_cs, bank_cart;
  logic [15:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  boot_lock_ctrl u_dut (
    .clk_i(clk), .rst_i(rst), .soft_rst_i(soft_rst), .lock_en_i(lock_en), .boot_en_i(boot_en),
    .acc_i(acc), .we_i(we), .uds_i(uds), .lds_i(lds), .addr_i(addr), .wdata_i(wdata),
    .vdp_open_o(vdp_open), .vdp_cs_o(vdp_cs), .lockup_o(lockup), .boot_cs_o(boot_cs),
    .cart_cs_o(cart_cs), .bank_cart_o(bank_cart), .rdata_o(rdata)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_sec [4];
  bit m_valid = 0;
  bit m_open, m_lockup, m_bank, e_vcs, e_boot, e_cart;
  logic [15:0] e_rdata;

  function automatic bit in_vdp(logic [23:0] a);
    return (a[23:16] >= 8'hC0) && (a[23:16] <= 8'hDF) && (a[18:16] == 3'd0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_sec[i]) m_sec[i] = 8'h00;
      m_open = !lock_en; m_lockup = 0; m_bank = !(lock_en && boot_en);
      e_vcs = 0; e_boot = 0; e_cart = 0; e_rdata = 0; m_valid = 1;
    end else if (m_valid) begin
      bit hv, bootm;
      hv = acc && in_vdp(addr);
      e_vcs = hv && m_open;
      if (soft_rst) m_lockup = 0;
      else if (hv && !m_open) m_lockup = 1;
      bootm = (addr < 24'h000800) && !m_bank;
      e_boot = acc && bootm;
      e_cart = acc && (addr < 24'h800000) && !bootm;
      e_rdata = (acc && !we && addr[23:1] == BNK[23:1]) ? {15'd0, m_bank} : 16'd0;
      if (acc && we && addr[23:2] == SEC[23:2]) begin
        int base;
        base = addr[1] ? 2 : 0;
        if (uds) m_sec[base]   = wdata[15:8];
        if (lds) m_sec[base+1] = wdata[7:0];
      end
      if (acc && we && lds && addr[23:1] == BNK[23:1]) m_bank = wdata[0];
      m_open = !lock_en || (m_sec[0] == 8'h53 && m_sec[1] == 8'h45 &&
                            m_sec[2] == 8'h47 && m_sec[3] == 8'h41);
    end
  end

  // cycle-by-cycle comparison, on the falling edge
  always @(negedge clk) begin
    if (m_valid) begin
      n_tests++;
      if (vdp_open !== m_open) begin n_fail++;
        $display("FAIL R2/R4 vdp_open actual=%0b expected=%0b", vdp_open, m_open); end
      if (vdp_cs !== e_vcs) begin n_fail++;
        $display("FAIL R6 vdp_cs actual=%0b expected=%0b", vdp_cs, e_vcs); end
      if (lockup !== m_lockup) begin n_fail++;
        $display("FAIL R6 lockup actual=%0b expected=%0b", lockup, m_lockup); end
      if (boot_cs !== e_boot || cart_cs !== e_cart) begin n_fail++;
        $display("FAIL R11 boot/cart actual=%0b%0b expected=%0b%0b", boot_cs, cart_cs, e_boot, e_cart); end
      if (bank_cart !== m_bank) begin n_fail++;
        $display("FAIL R8 bank actual=%0b expected=%0b", bank_cart, m_bank); end
      if (rdata !== e_rdata) begin n_fail++;
        $display("FAIL R9 rdata actual=%0h expected=%0h", rdata, e_rdata); end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit w, input bit u, input bit l, input logic [23:0] a, input logic [15:0] d);
    acc = 1; we = w; uds = u; lds = l; addr = a; wdata = d;
    @(negedge clk);
    acc = 0; we = 0; uds = 0; lds = 0; addr = 24'h0; wdata = 16'h0;
  endtask

  task automatic hard_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; soft_rst = 0; lock_en = 1; boot_en = 1;
    acc = 0; we = 0; uds = 0; lds = 0; addr = 0; wdata = 0;
    @(negedge clk);
    hard_reset();
    chk("R1 locked after hard reset", vdp_open, 0);
    chk("R10 boot ROM after reset", bank_cart, 0);

    bus(0, 1, 1, 24'hC00004, 0);
    chk("R6 refused access no cs", vdp_cs, 0);
    chk("R6 lockup set", lockup, 1);
    @(negedge clk);
    chk("R6 lockup sticky", lockup, 1);

    bus(0, 1, 1, 24'h000100, 0);
    chk("R11 boot select", boot_cs, 1);
    bus(0, 1, 1, 24'h000900, 0);
    chk("R11 cart select above boot", cart_cs, 1);

    bus(1, 1, 1, SEC + 0, 16'h4147);
    bus(1, 1, 1, SEC + 2, 16'h4553);
    chk("R2 reversed letters stay locked", vdp_open, 0);
    bus(1, 1, 1, SEC + 0, 16'h5345);
    chk("R2 half signature locked", vdp_open, 0);
    bus(1, 1, 1, SEC + 2, 16'h4741);
    chk("R2 signature unlocks", vdp_open, 1);

    bus(1, 0, 1, SEC + 2, 16'hFF00);
    chk("R4 broken signature relocks", vdp_open, 0);
    bus(1, 0, 1, SEC + 2, 16'h0041);
    chk("R3 odd byte restored", vdp_open, 1);
    bus(1, 1, 0, SEC + 2, 16'h47FF);
    chk("R3 even-byte-only write keeps odd byte", vdp_open, 1);

    bus(1, 1, 1, 24'hC00000, 16'h1234);
    chk("R5 page C0", vdp_cs, 1);
    bus(0, 1, 1, 24'hC80000, 0);
    chk("R5 page C8", vdp_cs, 1);
    bus(0, 1, 1, 24'hD00010, 0);
    chk("R5 page D0", vdp_cs, 1);
    bus(0, 1, 1, 24'hD8FFFE, 0);
    chk("R5 page D8", vdp_cs, 1);
    bus(0, 1, 1, 24'hC10000, 0);
    chk("R5 page C1 not video", vdp_cs, 0);
    bus(0, 1, 1, 24'hE00000, 0);
    chk("R5 page E0 not video", vdp_cs, 0);

    bus(1, 1, 1, BNK, 16'h0001);
    chk("R8 bank to cart", bank_cart, 1);
    bus(0, 1, 1, BNK, 0);
    chk("R9 readback cart", rdata, 16'h0001);
    bus(1, 1, 0, BNK, 16'h0000);
    chk("R8 upper-only write ignored", bank_cart, 1);
    bus(0, 1, 1, 24'h000100, 0);
    chk("R11 cart at zero", cart_cs, 1);
    bus(1, 0, 1, BNK, 16'h0000);
    bus(0, 1, 1, BNK, 0);
    chk("R9 readback boot", rdata, 16'h0000);
    bus(1, 0, 1, BNK, 16'h0001);

    soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk("R1 soft reset keeps unlock", vdp_open, 1);
    chk("R6 soft reset clears lockup", lockup, 0);
    chk("R10 soft reset keeps bank", bank_cart, 1);

    hard_reset();
    chk("R1 hard reset relocks", vdp_open, 0);
    chk("R10 hard reset bank boot", bank_cart, 0);

    lock_en = 0;
    hard_reset();
    chk("R7 open without lock", vdp_open, 1);
    chk("R10 bank cart when lock off", bank_cart, 1);
    bus(0, 1, 1, 24'hC00000, 0);
    chk("R7 access granted", vdp_cs, 1);
    chk("R7 no lockup", lockup, 0);

    lock_en = 1; boot_en = 0;
    hard_reset();
    chk("R10 bank cart when boot off", bank_cart, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule